// File: doc/BRIEF.md
# Low-Side Switch Enable and Fault Status Logic

This block holds the digital control and fault bookkeeping for a bank of low-side power switches. It keeps a control word that a serial front end writes, and combines it with two active-low parallel PWM pins that can drive the first two channels directly. From these it produces one gate enable per channel. Overload events reach it as flags from the analog side. Channels 3 to 8 take an overcurrent flag, and channels 1 and 2 take an overtemperature flag. Either flag switches the affected channel off in the same cycle and holds it off in a per-channel overload latch.

Every channel also reports a diagnostic status bit. It is formed from the channel's commanded state and a comparator flag that says whether the output voltage is above the diagnostic threshold. On channels 3 to 8 this bit goes straight to the status word. On channels 1 and 2 the fault condition first passes a counter-based debounce filter and then sets a fault latch. That latch is cleared whenever chip select is low. As a result, the status captured at the start of a serial read shows what was latched before that read.

A single internal reset acts on the whole block. It is asserted when the external active-low reset pin is low or when the undervoltage flag is high.

Top module: `lsd_drive_ctrl`

## Requirements
- R1: Channels 1 and 2 (bits 0 and 1) have their gate enabled when their parallel input `pwm_n` bit is 0 or their control bit is 1, unless an overload is active. With `pwm_n` high and control bit 0 they are off.
- R2: Control word bit i commands channel i+1. It is taken from `wr_word` on a clock edge where `wr_stb` is 1. Channels 3 to 8 (bits 2 to 7) have their gate enabled exactly when their stored bit is 1, unless an overload is active.
- R3: When `ext_rst_n` is 0 or `uv_flag` is 1, every gate enable is 0 in that same cycle. The next edge clears the control word, the overload latches, the filters and the fault latches. After that, bits 0 and 1 of `diag_word` read 1 and bits 2 to 7 follow `v_high`.
- R4: On channels 3 to 8, a 1 on the matching `oc_flag` bit (bit i-2 for channel bit i) turns the gate off in the same cycle. The gate stays off after the flag returns to 0.
- R5: On channels 1 and 2, a 1 on `ot_flag` while the channel is commanded on turns the gate off in the same cycle. The gate stays off after the flag clears, even if `pwm_n` is driven low.
- R6: An overload latch is released only by a write that carries 0 in that channel's bit, or by reset. A write with 1 leaves the channel off.
- R7: For channels 3 to 8, the `diag_word` bit equals `v_high` while no overload is latched. It reads 1 while an overload is latched.
- R8: The raw fault on channels 1 and 2 is present in two cases. The first is commanded on with `v_high` 1 or an overload latched. The second is commanded off with `v_high` 0. A latched fault reads 0 in `diag_word`, and no fault reads 1.
- R9: A raw fault on channels 1 or 2 must be present for FILT_CYC consecutive clock edges before the filter flags it. The status bit falls one edge later. A shorter fault pulse leaves the status at 1.
- R10: A latched fault on channels 1 and 2 stays latched after the condition goes away while `cs_n` is 1. An edge with `cs_n` 0 clears it. If the filtered fault is still present, it sets again on the first edge with `cs_n` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| ext_rst_n | input | 1 | External reset, active low |
| uv_flag | input | 1 | Supply undervoltage flag, active high |
| cs_n | input | 1 | Serial chip select, active low; clears channel 1/2 fault latches |
| wr_stb | input | 1 | One-cycle strobe that stores `wr_word` |
| wr_word | input | CH_NUM | New control word, bit i for channel i+1 |
| pwm_n | input | PAR_NUM | Active-low parallel control for channels 1 and 2 |
| oc_flag | input | CH_NUM-PAR_NUM | Overcurrent flags for channels 3 to 8 |
| ot_flag | input | PAR_NUM | Overtemperature flags for channels 1 and 2 |
| v_high | input | CH_NUM | Output voltage above diagnostic threshold, per channel |
| gate_en | output | CH_NUM | Gate enable per channel |
| diag_word | output | CH_NUM | Diagnostic status bit per channel |

## Verification
The bench builds the block with eight channels, two of them parallel-capable, and a filter length of 4 cycles in place of the long default. With this setting a fault that falls short of the window by one cycle and a fault that just fills it can both be shown within a few edges. The latch-hold and chip-select clear sequences of R10 also fit into short directed runs. The overload tests use the default channel split, so they reach both variants of the channel: the overcurrent-latched one and the overtemperature-latched one.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    localparam int unsigned LSD_CH_DEF  = 8;
    localparam int unsigned LSD_PAR_DEF = 2;

    // what a channel exposes to its status encoder
    typedef struct packed {
        logic cmd_on;
        logic v_high;
        logic ovl;
    } chan_obs_t;

    // per-channel switch result
    typedef struct packed {
        logic gate;
        logic ovl;
    } chan_out_t;

    // parallel-capable channel: on if pin low or stored bit set
    function automatic logic par_cmd(input logic pin_n, input logic ctrl_bit);
        return ~pin_n | ctrl_bit;
    endfunction

    // channels 1/2: fault when on and high (or tripped), or off and low
    function automatic logic par_raw_fault(input chan_obs_t o);
        return o.cmd_on ? (o.v_high | o.ovl) : ~o.v_high;
    endfunction

    // channels 3..8: comparator straight through, forced high while tripped
    function automatic logic ser_status(input chan_obs_t o);
        return o.v_high | o.ovl;
    endfunction

endpackage

// File: rtl/lsd_ctrl_word.sv
module lsd_ctrl_word #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/lsd_chan_switch.sv
module lsd_chan_switch
    import lsd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_on,
    input  logic      trip,
    input  logic      clr,
    output chan_out_t q
);

    logic ovl_q;

    // overload latch: release by a write of 0 dominates a new trip
    always_ff @(posedge clk) begin
        if (rst) begin
            ovl_q <= 1'b0;
        end else if (clr) begin
            ovl_q <= 1'b0;
        end else if (cmd_on && trip) begin
            ovl_q <= 1'b1;
        end
    end

    // trip acts on the gate in the same cycle, the latch holds it off after
    always_comb begin
        q.gate = cmd_on & ~ovl_q & ~trip & ~rst;
        q.ovl  = ovl_q;
    end

endmodule

// File: rtl/lsd_diag_filter.sv
module lsd_diag_filter #(
    parameter int unsigned FILT_CYC = 750
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic raw_fault,
    output logic ok
);

    localparam int unsigned CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          filt_q;
    logic          flt_q;

    // the filtered flag follows the raw flag only after FILT_CYC equal samples
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (raw_fault == filt_q) begin
            cnt_q  <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            filt_q <= raw_fault;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // select low clears; otherwise a filtered fault sets and holds
    always_ff @(posedge clk) begin
        if (rst) begin
            flt_q <= 1'b0;
        end else if (!cs_n) begin
            flt_q <= 1'b0;
        end else if (filt_q) begin
            flt_q <= 1'b1;
        end
    end

    assign ok = ~flt_q;

endmodule

// File: rtl/lsd_drive_ctrl.sv
module lsd_drive_ctrl
    import lsd_pkg::*;
#(
    parameter int unsigned CH_NUM   = LSD_CH_DEF,
    parameter int unsigned PAR_NUM  = LSD_PAR_DEF,
    parameter int unsigned FILT_CYC = 750
) (
    input  logic                      clk,
    input  logic                      ext_rst_n,
    input  logic                      uv_flag,
    input  logic                      cs_n,
    input  logic                      wr_stb,
    input  logic [CH_NUM-1:0]         wr_word,
    input  logic [PAR_NUM-1:0]        pwm_n,
    input  logic [CH_NUM-PAR_NUM-1:0] oc_flag,
    input  logic [PAR_NUM-1:0]        ot_flag,
    input  logic [CH_NUM-1:0]         v_high,
    output logic [CH_NUM-1:0]         gate_en,
    output logic [CH_NUM-1:0]         diag_word
);

    logic              rst_int;
    logic [CH_NUM-1:0] ctrl_q;

    assign rst_int = ~ext_rst_n | uv_flag;

    lsd_ctrl_word #(.W(CH_NUM)) u_ctrl (
        .clk  (clk),
        .rst  (rst_int),
        .load (wr_stb),
        .d    (wr_word),
        .q    (ctrl_q)
    );

    for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
        logic      cmd_i;
        logic      trip_i;
        chan_out_t sw_q;
        chan_obs_t obs;

        if (i < PAR_NUM) begin : g_par
            logic fault_raw;
            assign cmd_i     = par_cmd(pwm_n[i], ctrl_q[i]);
            assign trip_i    = ot_flag[i];
            assign fault_raw = par_raw_fault(obs);

            lsd_diag_filter #(.FILT_CYC(FILT_CYC)) u_filt (
                .clk       (clk),
                .rst       (rst_int),
                .cs_n      (cs_n),
                .raw_fault (fault_raw),
                .ok        (diag_word[i])
            );
        end else begin : g_ser
            assign cmd_i        = ctrl_q[i];
            assign trip_i       = oc_flag[i-PAR_NUM];
            assign diag_word[i] = ser_status(obs);
        end

        lsd_chan_switch u_sw (
            .clk    (clk),
            .rst    (rst_int),
            .cmd_on (cmd_i),
            .trip   (trip_i),
            .clr    (wr_stb & ~wr_word[i]),
            .q      (sw_q)
        );

        assign obs        = '{cmd_on: cmd_i, v_high: v_high[i], ovl: sw_q.ovl};
        assign gate_en[i] = sw_q.gate;
    end

endmodule

// File: rtl/lsd_drive_ctrl_chk.sv
module lsd_drive_ctrl_chk #(
    parameter int unsigned CH_NUM   = 8,
    parameter int unsigned PAR_NUM  = 2,
    parameter int unsigned FILT_CYC = 750
) (
    input logic                      clk,
    input logic                      ext_rst_n,
    input logic                      uv_flag,
    input logic                      cs_n,
    input logic                      wr_stb,
    input logic [CH_NUM-1:0]         wr_word,
    input logic [PAR_NUM-1:0]        pwm_n,
    input logic [CH_NUM-PAR_NUM-1:0] oc_flag,
    input logic [PAR_NUM-1:0]        ot_flag,
    input logic [CH_NUM-1:0]         v_high,
    input logic [CH_NUM-1:0]         gate_en,
    input logic [CH_NUM-1:0]         diag_word
);

    logic rst_c;
    assign rst_c = !ext_rst_n || uv_flag;

    // R3: no gate may be enabled in any sampled reset cycle
    always_ff @(posedge clk) begin
        if (rst_c) begin
            assert_rst_gates_off_R3: assert (gate_en == '0)
                else $error("gate enabled during reset");
        end
    end

    for (genvar k = 0; k < CH_NUM; k++) begin : g_a
        if (k < PAR_NUM) begin : g_par
            // R5: overtemperature while driven by the pin leaves the gate off next cycle
            assert_ot_latch_R5: assert property (@(posedge clk) disable iff (rst_c)
                (ot_flag[k] && !pwm_n[k] && !wr_stb) |=> !gate_en[k]);
            // R10: an edge with select low leaves the fault latch clear
            assert_cs_clears_R10: assert property (@(posedge clk) disable iff (rst_c)
                !cs_n |=> diag_word[k]);
            // R10: a new fault can only appear after an edge with select high
            assert_fault_needs_cs_high_R10: assert property (@(posedge clk) disable iff (rst_c)
                $fell(diag_word[k]) |-> $past(cs_n));
        end else begin : g_ser
            // R4: overcurrent without a write keeps the channel off next cycle
            assert_oc_latch_R4: assert property (@(posedge clk) disable iff (rst_c)
                (oc_flag[k-PAR_NUM] && !wr_stb) |=> !gate_en[k]);
            // R2: writing 0 switches the channel off
            assert_wr_off_R2: assert property (@(posedge clk) disable iff (rst_c)
                (wr_stb && !wr_word[k]) |=> !gate_en[k]);
            // R7: comparator high always reads as 1
            assert_ser_status_R7: assert property (@(posedge clk) disable iff (rst_c)
                v_high[k] |-> diag_word[k]);
        end
    end

endmodule

bind lsd_drive_ctrl lsd_drive_ctrl_chk #(
    .CH_NUM   (CH_NUM),
    .PAR_NUM  (PAR_NUM),
    .FILT_CYC (FILT_CYC)
) u_chk (.*);

// File: tb/lsd_drive_ctrl_bench.sv
module lsd_drive_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CH   = 8;
    localparam int PAR  = 2;
    localparam int FILT = 4;

    logic            clk = 1'b0;
    logic            ext_rst_n;
    logic            uv_flag;
    logic            cs_n;
    logic            wr_stb;
    logic [CH-1:0]   wr_word;
    logic [PAR-1:0]  pwm_n;
    logic [CH-PAR-1:0] oc_flag;
    logic [PAR-1:0]  ot_flag;
    logic [CH-1:0]   v_high;
    logic [CH-1:0]   gate_en;
    logic [CH-1:0]   diag_word;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsd_drive_ctrl #(.CH_NUM(CH), .PAR_NUM(PAR), .FILT_CYC(FILT)) u_lsd_drive_ctrl (
        .clk       (clk),
        .ext_rst_n (ext_rst_n),
        .uv_flag   (uv_flag),
        .cs_n      (cs_n),
        .wr_stb    (wr_stb),
        .wr_word   (wr_word),
        .pwm_n     (pwm_n),
        .oc_flag   (oc_flag),
        .ot_flag   (ot_flag),
        .v_high    (v_high),
        .gate_en   (gate_en),
        .diag_word (diag_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic [CH-1:0] w);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_word = w;
        @(negedge clk);
        wr_stb  = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        ext_rst_n = 1'b0;
        wait_n(2);
        ext_rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        ext_rst_n = 1'b0;
        pwm_n     = 2'b00;
        #1;
        chk("R3 gates off while reset", gate_en, 8'h00);
        wait_n(2);
        pwm_n     = 2'b11;
        v_high    = 8'b1010_0011;
        ext_rst_n = 1'b1;
        #1;
        chk("R3 status after reset", diag_word, 8'b1010_0011);
        chk("R3 gates after reset", gate_en, 8'h00);
    endtask

    task automatic t_par_or();
        do_reset();
        pwm_n = 2'b10;
        #1;
        chk("R1 pin low turns ch1 on", gate_en, 8'h01);
        pwm_n = 2'b11;
        #1;
        chk("R1 pin high ctrl 0 is off", gate_en, 8'h00);
        write_word(8'h02);
        chk("R1 ctrl bit turns ch2 on", gate_en, 8'h02);
        pwm_n = 2'b10;
        #1;
        chk("R1 pin and ctrl combine", gate_en, 8'h03);
        pwm_n = 2'b11;
    endtask

    task automatic t_ser();
        do_reset();
        write_word(8'hA5);
        chk("R2 word A5", gate_en, 8'hA5);
        write_word(8'h5A);
        chk("R2 word 5A", gate_en, 8'h5A);
    endtask

    task automatic t_oc();
        do_reset();
        v_high = 8'h03;
        write_word(8'h58);
        chk("R2 ch bits 3,4,6 on", gate_en, 8'h58);
        @(negedge clk);
        oc_flag = 6'b00_0010;
        #1;
        chk("R4 gate off at once", gate_en, 8'h50);
        @(negedge clk);
        oc_flag = '0;
        wait_n(2);
        chk("R4 stays off after flag", gate_en, 8'h50);
        chk("R7 tripped channel reads 1", diag_word[3], 1'b1);
        chk("R7 others follow comparator", diag_word[7:4], 4'h0);
        write_word(8'h58);
        chk("R6 write of 1 keeps latch", gate_en, 8'h50);
        write_word(8'h50);
        chk("R6 write of 0 releases", diag_word[3], 1'b0);
        write_word(8'h58);
        chk("R6 back on after release", gate_en, 8'h58);
        v_high = 8'hA3;
        #1;
        chk("R7 comparator high reads 1", diag_word[7:2], 6'b101000);
        v_high = 8'h03;
    endtask

    task automatic t_uv();
        write_word(8'hF0);
        @(negedge clk);
        uv_flag = 1'b1;
        #1;
        chk("R3 undervoltage gates off", gate_en, 8'h00);
        @(negedge clk);
        uv_flag = 1'b0;
        #1;
        chk("R3 control word cleared", gate_en, 8'h00);
    endtask

    task automatic t_ot();
        do_reset();
        write_word(8'h01);
        chk("R1 ch1 on by ctrl", gate_en[0], 1'b1);
        @(negedge clk);
        ot_flag = 2'b01;
        #1;
        chk("R5 overtemp off at once", gate_en[0], 1'b0);
        @(negedge clk);
        ot_flag = 2'b00;
        pwm_n   = 2'b10;
        wait_n(2);
        chk("R5 latched despite pin low", gate_en[0], 1'b0);
        write_word(8'h00);
        chk("R6 release by write 0", gate_en[0], 1'b1);
        pwm_n = 2'b11;
    endtask

    task automatic t_filter();
        v_high = 8'h03;
        cs_n   = 1'b1;
        do_reset();
        @(negedge clk);
        v_high[0] = 1'b0;
        wait_n(FILT - 1);
        v_high[0] = 1'b1;
        wait_n(6);
        chk("R9 short pulse ignored", diag_word[0], 1'b1);
        v_high[0] = 1'b0;
        wait_n(FILT);
        chk("R9 status before window ends", diag_word[0], 1'b1);
        wait_n(1);
        chk("R8 off and low is a fault", diag_word[0], 1'b0);
        v_high[0] = 1'b1;
        wait_n(8);
        chk("R10 latch holds with cs high", diag_word[0], 1'b0);
        cs_n = 1'b0;
        wait_n(1);
        chk("R10 cs low clears", diag_word[0], 1'b1);
        cs_n = 1'b1;
        wait_n(3);
        chk("R10 stays clear without fault", diag_word[0], 1'b1);
    endtask

    task automatic t_on_fault();
        do_reset();
        write_word(8'h02);
        v_high[1] = 1'b1;
        wait_n(FILT + 1);
        chk("R8 on and high is a fault", diag_word[1], 1'b0);
        cs_n = 1'b0;
        wait_n(1);
        chk("R10 cleared while selected", diag_word[1], 1'b1);
        cs_n = 1'b1;
        wait_n(1);
        chk("R10 persistent fault re-latches", diag_word[1], 1'b0);
        v_high[1] = 1'b0;
        wait_n(FILT + 1);
        cs_n = 1'b0;
        wait_n(1);
        cs_n = 1'b1;
        wait_n(3);
        chk("R8 on and low is healthy", diag_word[1], 1'b1);
    endtask

    initial begin
        ext_rst_n = 1'b0;
        uv_flag   = 1'b0;
        cs_n      = 1'b1;
        wr_stb    = 1'b0;
        wr_word   = '0;
        pwm_n     = 2'b11;
        oc_flag   = '0;
        ot_flag   = '0;
        v_high    = 8'h03;
        t_reset();
        t_par_or();
        t_ser();
        t_oc();
        t_uv();
        t_ot();
        t_filter();
        t_on_fault();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule